// File: doc/BRIEF.md
# Address-Space-Tagged Fully Associative Translation Buffer

This block holds a parameterized number of page translations. Each slot stores a virtual page tag, a physical frame, an address-space identifier, a shared flag and an attribute set. The attribute set holds per-privilege-mode read and write permission masks and two trap flags, one raised on read and one raised on write. A probe with a page number and the current address-space identifier returns in the same cycle. It reports whether a slot matched, the index of that slot, and its frame and attributes. A slot whose shared flag is set matches under every identifier.

New translations are written at a round-robin slot pointer, and any valid entry already in that slot is discarded. A separate command advances the pointer without writing anything. The caller reads the pointer at the port to learn which slot the command reserved. Three invalidation commands exist. The first empties the whole buffer and resets the pointer. The second discards every private (non-shared) entry. The third discards the entries that one page would hit under one identifier. All commands take effect at the rising clock edge.

Top module: `asn_tlb`

## Requirements
- R1: A probe hits only on a valid slot whose tag equals `lk_vpn` and that has its shared flag set or a stored identifier equal to `lk_asid`. On a miss, `lk_hit` is 0 and every field output is 0.
- R2: When several slots hit, `lk_idx` and the field outputs come from the lowest-indexed hitting slot.
- R3: Command code 1 (fill) writes `cmd_vpn`, `cmd_asid`, `fill_pfn` and the fill attributes into the slot at `repl_ptr` and marks it valid. Any entry held there before is lost. The new entry is visible to probes from the next cycle.
- R4: After a fill, `repl_ptr` moves to the next slot and wraps from ENTRIES-1 to 0. Only fill, skip and flush-all change the pointer.
- R5: Command code 5 (skip) advances `repl_ptr` exactly as a fill does and leaves every slot unchanged.
- R6: Command code 2 (flush-all) makes every slot invalid and sets `repl_ptr` to 0.
- R7: Command code 3 (flush-private) invalidates every slot whose shared flag is clear and keeps shared slots.
- R8: Command code 4 (flush-one) invalidates every valid slot whose tag equals `cmd_vpn` and that is shared or holds `cmd_asid`. Other slots are kept.
- R9: After reset, no probe hits and `repl_ptr` is 0.
- R10: Command codes 0, 6 and 7 leave every slot and the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command code (0 idle, 1 fill, 2 flush-all, 3 flush-private, 4 flush-one, 5 skip) |
| cmd_vpn | input | VPN_W | Page number for fill and flush-one |
| cmd_asid | input | ASID_W | Identifier for fill and flush-one |
| fill_pfn | input | PFN_W | Frame written by fill |
| fill_global | input | 1 | Shared flag written by fill |
| fill_rd_perm | input | 4 | Per-mode read permission mask written by fill |
| fill_wr_perm | input | 4 | Per-mode write permission mask written by fill |
| fill_trap_rd | input | 1 | Trap-on-read flag written by fill |
| fill_trap_wr | input | 1 | Trap-on-write flag written by fill |
| lk_vpn | input | VPN_W | Probe page number |
| lk_asid | input | ASID_W | Probe identifier |
| lk_hit | output | 1 | Probe hit |
| lk_idx | output | IDX_W | Index of the selected slot |
| lk_pfn | output | PFN_W | Frame of the selected slot |
| lk_global | output | 1 | Shared flag of the selected slot |
| lk_rd_perm | output | 4 | Read mask of the selected slot |
| lk_wr_perm | output | 4 | Write mask of the selected slot |
| lk_trap_rd | output | 1 | Trap-on-read flag of the selected slot |
| lk_trap_wr | output | 1 | Trap-on-write flag of the selected slot |
| repl_ptr | output | IDX_W | Slot the next fill or skip will use |

## Verification
The bench loads the same page under several identifiers and places a shared entry below a private duplicate. A design that ignored the identifier, or that selected the highest match, would then return the wrong slot. Each command is followed by a sweep of every identifier over a set of pages. The sweeps expose a flush-one that also drops entries of other address spaces, a flush-private that removes shared slots, and a skip that corrupts a slot. The slot count is six, which is not a power of two, so a pointer that wraps at the binary limit instead of at the last slot lands on a slot that does not exist.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;

    localparam int unsigned PERM_MODES = 4;

    typedef enum logic [2:0] {
        CMD_IDLE        = 3'd0,
        CMD_FILL        = 3'd1,
        CMD_FLUSH_ALL   = 3'd2,
        CMD_FLUSH_LOCAL = 3'd3,
        CMD_FLUSH_ONE   = 3'd4,
        CMD_SKIP        = 3'd5
    } tlb_cmd_e;

    typedef struct packed {
        logic [PERM_MODES-1:0] rd_perm;
        logic [PERM_MODES-1:0] wr_perm;
        logic                  trap_rd;
        logic                  trap_wr;
        logic                  global_pg;
    } attr_t;

    // Commands that consume a slot of the round-robin pointer.
    function automatic logic moves_pointer(tlb_cmd_e c);
        return (c == CMD_FILL) || (c == CMD_SKIP);
    endfunction

endpackage

// File: rtl/tlb_tag_cmp.sv
`timescale 1ns/1ps
module tlb_tag_cmp #(
    parameter int unsigned N      = 4,
    parameter int unsigned VPN_W  = 8,
    parameter int unsigned ASID_W = 4
) (
    input  logic [N-1:0]      valid,
    input  logic [N-1:0]      shared,
    input  logic [VPN_W-1:0]  tags  [N],
    input  logic [ASID_W-1:0] asids [N],
    input  logic [VPN_W-1:0]  probe_vpn,
    input  logic [ASID_W-1:0] probe_asid,
    output logic [N-1:0]      hits
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic tag_eq;
        logic space_ok;
        assign tag_eq   = (tags[g] == probe_vpn);
        assign space_ok = shared[g] || (asids[g] == probe_asid);
        assign hits[g]  = valid[g] && tag_eq && space_ok;
    end
endmodule

// File: rtl/tlb_first_set.sv
`timescale 1ns/1ps
module tlb_first_set #(
    parameter int unsigned N     = 4,
    localparam int unsigned IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit is the last one assigned.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_rr_ptr.sv
`timescale 1ns/1ps
module tlb_rr_ptr #(
    parameter int unsigned N   = 4,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    input  logic          clear,
    output logic [IW-1:0] ptr
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= (ptr == LAST) ? '0 : ptr + IW'(1);
        end
    end
endmodule

// File: rtl/asn_tlb.sv
`timescale 1ns/1ps
module asn_tlb
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 48,
    parameter int unsigned VPN_W   = 30,
    parameter int unsigned PFN_W   = 27,
    parameter int unsigned ASID_W  = 8,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2:0]            cmd,
    input  logic [VPN_W-1:0]      cmd_vpn,
    input  logic [ASID_W-1:0]     cmd_asid,
    input  logic [PFN_W-1:0]      fill_pfn,
    input  logic                  fill_global,
    input  logic [PERM_MODES-1:0] fill_rd_perm,
    input  logic [PERM_MODES-1:0] fill_wr_perm,
    input  logic                  fill_trap_rd,
    input  logic                  fill_trap_wr,
    input  logic [VPN_W-1:0]      lk_vpn,
    input  logic [ASID_W-1:0]     lk_asid,
    output logic                  lk_hit,
    output logic [IDX_W-1:0]      lk_idx,
    output logic [PFN_W-1:0]      lk_pfn,
    output logic                  lk_global,
    output logic [PERM_MODES-1:0] lk_rd_perm,
    output logic [PERM_MODES-1:0] lk_wr_perm,
    output logic                  lk_trap_rd,
    output logic                  lk_trap_wr,
    output logic [IDX_W-1:0]      repl_ptr
);
    tlb_cmd_e op;
    assign op = tlb_cmd_e'(cmd);

    // Slot storage
    logic [ENTRIES-1:0] ent_valid;
    logic [ENTRIES-1:0] ent_shared;
    logic [VPN_W-1:0]   ent_tag  [ENTRIES];
    logic [ASID_W-1:0]  ent_asid [ENTRIES];
    logic [PFN_W-1:0]   ent_pfn  [ENTRIES];
    attr_t              ent_attr [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_shared
        assign ent_shared[g] = ent_attr[g].global_pg;
    end

    attr_t new_attr;
    assign new_attr = '{rd_perm:   fill_rd_perm,
                        wr_perm:   fill_wr_perm,
                        trap_rd:   fill_trap_rd,
                        trap_wr:   fill_trap_wr,
                        global_pg: fill_global};

    // Probe and flush-one comparators share one structure.
    logic [ENTRIES-1:0] probe_hits;
    logic [ENTRIES-1:0] kill_hits;

    tlb_tag_cmp #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_probe_cmp (
        .valid      (ent_valid),
        .shared     (ent_shared),
        .tags       (ent_tag),
        .asids      (ent_asid),
        .probe_vpn  (lk_vpn),
        .probe_asid (lk_asid),
        .hits       (probe_hits)
    );

    tlb_tag_cmp #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_kill_cmp (
        .valid      (ent_valid),
        .shared     (ent_shared),
        .tags       (ent_tag),
        .asids      (ent_asid),
        .probe_vpn  (cmd_vpn),
        .probe_asid (cmd_asid),
        .hits       (kill_hits)
    );

    tlb_first_set #(.N(ENTRIES)) u_pick (
        .req   (probe_hits),
        .found (lk_hit),
        .idx   (lk_idx)
    );

    tlb_rr_ptr #(.N(ENTRIES)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .advance (moves_pointer(op)),
        .clear   (op == CMD_FLUSH_ALL),
        .ptr     (repl_ptr)
    );

    // Valid bits: the only state that reset and the flush commands touch.
    always_ff @(posedge clk) begin
        if (rst) begin
            ent_valid <= '0;
        end else begin
            case (op)
                CMD_FILL:        ent_valid[repl_ptr] <= 1'b1;
                CMD_FLUSH_ALL:   ent_valid <= '0;
                CMD_FLUSH_LOCAL: ent_valid <= ent_valid & ent_shared;
                CMD_FLUSH_ONE:   ent_valid <= ent_valid & ~kill_hits;
                default:         ;
            endcase
        end
    end

    // Payload is written only by a fill; stale payload behind a clear
    // valid bit is never selected.
    always_ff @(posedge clk) begin
        if (op == CMD_FILL) begin
            ent_tag[repl_ptr]  <= cmd_vpn;
            ent_asid[repl_ptr] <= cmd_asid;
            ent_pfn[repl_ptr]  <= fill_pfn;
            ent_attr[repl_ptr] <= new_attr;
        end
    end

    // Result mux, forced to zero on a miss.
    attr_t sel_attr;
    always_comb begin
        lk_pfn   = '0;
        sel_attr = '0;
        if (lk_hit) begin
            lk_pfn   = ent_pfn[lk_idx];
            sel_attr = ent_attr[lk_idx];
        end
    end

    assign lk_global  = sel_attr.global_pg;
    assign lk_rd_perm = sel_attr.rd_perm;
    assign lk_wr_perm = sel_attr.wr_perm;
    assign lk_trap_rd = sel_attr.trap_rd;
    assign lk_trap_wr = sel_attr.trap_wr;

endmodule

// File: rtl/asn_tlb_checker.sv
`timescale 1ns/1ps
module asn_tlb_checker
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 48,
    parameter int unsigned VPN_W   = 30,
    parameter int unsigned PFN_W   = 27,
    parameter int unsigned ASID_W  = 8,
    localparam int unsigned IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        cmd,
    input logic [VPN_W-1:0]  cmd_vpn,
    input logic [ASID_W-1:0] cmd_asid,
    input logic [VPN_W-1:0]  lk_vpn,
    input logic [ASID_W-1:0] lk_asid,
    input logic              lk_hit,
    input logic [IW-1:0]     lk_idx,
    input logic [PFN_W-1:0]  lk_pfn,
    input logic [IW-1:0]     repl_ptr
);
    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (repl_ptr == '0 && !lk_hit));                          // R9

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_FILL || cmd == CMD_SKIP) |=>
            repl_ptr == (($past(repl_ptr) == IW'(ENTRIES - 1)) ? '0
                                                              : $past(repl_ptr) + IW'(1))); // R4

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_FILL && cmd != CMD_SKIP && cmd != CMD_FLUSH_ALL) |=> $stable(repl_ptr)); // R4

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_FLUSH_ALL) |=> (repl_ptr == '0 && !lk_hit));              // R6

    AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_FILL) ##1 (lk_vpn == $past(cmd_vpn) && lk_asid == $past(cmd_asid))
            |-> lk_hit);                                                       // R3

    AST_IDX_LEGAL: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (int'(lk_idx) < ENTRIES));                                  // R2

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_pfn == '0));                                           // R1
endmodule

bind asn_tlb asn_tlb_checker #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PFN_W   (PFN_W),
    .ASID_W  (ASID_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .cmd_vpn  (cmd_vpn),
    .cmd_asid (cmd_asid),
    .lk_vpn   (lk_vpn),
    .lk_asid  (lk_asid),
    .lk_hit   (lk_hit),
    .lk_idx   (lk_idx),
    .lk_pfn   (lk_pfn),
    .repl_ptr (repl_ptr)
);

// File: tb/asn_tlb_tb_top.sv
`timescale 1ns/1ps
module asn_tlb_tb_top;
    import tlb_pkg::*;

    localparam int N  = 6;
    localparam int VW = 8;
    localparam int PW = 8;
    localparam int AW = 3;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0]   cmd = '0;
    logic [VW-1:0] cmd_vpn = '0;
    logic [AW-1:0] cmd_asid = '0;
    logic [PW-1:0] fill_pfn = '0;
    logic fill_global = 1'b0;
    logic [3:0] fill_rd_perm = '0, fill_wr_perm = '0;
    logic fill_trap_rd = 1'b0, fill_trap_wr = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic [AW-1:0] lk_asid = '0;
    logic lk_hit, lk_global, lk_trap_rd, lk_trap_wr;
    logic [IW-1:0] lk_idx, repl_ptr;
    logic [PW-1:0] lk_pfn;
    logic [3:0] lk_rd_perm, lk_wr_perm;

    always #2.5 clk = ~clk;

    asn_tlb #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW)) dut_i (
        .clk(clk), .rst(rst), .cmd(cmd), .cmd_vpn(cmd_vpn), .cmd_asid(cmd_asid),
        .fill_pfn(fill_pfn), .fill_global(fill_global), .fill_rd_perm(fill_rd_perm),
        .fill_wr_perm(fill_wr_perm), .fill_trap_rd(fill_trap_rd), .fill_trap_wr(fill_trap_wr),
        .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_hit(lk_hit), .lk_idx(lk_idx),
        .lk_pfn(lk_pfn), .lk_global(lk_global), .lk_rd_perm(lk_rd_perm),
        .lk_wr_perm(lk_wr_perm), .lk_trap_rd(lk_trap_rd), .lk_trap_wr(lk_trap_wr),
        .repl_ptr(repl_ptr)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Expected state, derived from the requirements.
    bit          m_valid [N];
    bit [VW-1:0] m_vpn   [N];
    bit [AW-1:0] m_asid  [N];
    bit [PW-1:0] m_pfn   [N];
    attr_t       m_attr  [N];
    int          m_ptr;

    function automatic attr_t attr_for(int k, bit glob);
        attr_t a;
        a.rd_perm   = 4'(k * 3 + 1);
        a.wr_perm   = 4'(k ^ 5);
        a.trap_rd   = k[0];
        a.trap_wr   = k[1];
        a.global_pg = glob;
        return a;
    endfunction

    task automatic model_apply(input int c, input bit [VW-1:0] v, input bit [AW-1:0] a,
                               input bit [PW-1:0] p, input attr_t at);
        case (c)
            1: begin
                m_valid[m_ptr] = 1'b1; m_vpn[m_ptr] = v; m_asid[m_ptr] = a;
                m_pfn[m_ptr] = p; m_attr[m_ptr] = at;
                m_ptr = (m_ptr == N - 1) ? 0 : m_ptr + 1;
            end
            2: begin
                for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
                m_ptr = 0;
            end
            3: for (int i = 0; i < N; i++) if (!m_attr[i].global_pg) m_valid[i] = 1'b0;
            4: for (int i = 0; i < N; i++)
                   if (m_valid[i] && m_vpn[i] == v && (m_attr[i].global_pg || m_asid[i] == a))
                       m_valid[i] = 1'b0;
            5: m_ptr = (m_ptr == N - 1) ? 0 : m_ptr + 1;
            default: ;
        endcase
    endtask

    task automatic issue(input int c, input bit [VW-1:0] v, input bit [AW-1:0] a,
                         input bit [PW-1:0] p, input attr_t at);
        @(negedge clk);
        cmd = 3'(c); cmd_vpn = v; cmd_asid = a; fill_pfn = p;
        fill_global = at.global_pg; fill_rd_perm = at.rd_perm; fill_wr_perm = at.wr_perm;
        fill_trap_rd = at.trap_rd; fill_trap_wr = at.trap_wr;
        @(posedge clk);
        model_apply(c, v, a, p, at);
        @(negedge clk);
        cmd = 3'd0;
    endtask

    task automatic fill(input int k, input bit [VW-1:0] v, input bit [AW-1:0] a, input bit glob);
        issue(1, v, a, 8'(8'hA0 + k), attr_for(k, glob));
    endtask

    task automatic check_ptr(input string tag);
        #1;
        checks++;
        if (int'(repl_ptr) != m_ptr) begin
            errors++;
            $display("FAIL %s: repl_ptr got %0d exp %0d", tag, repl_ptr, m_ptr);
        end
    endtask

    task automatic probe(input bit [VW-1:0] v, input bit [AW-1:0] a, input string tag);
        int  e_idx = -1;
        bit  ok;
        lk_vpn = v; lk_asid = a;
        #1;
        for (int i = N - 1; i >= 0; i--)
            if (m_valid[i] && m_vpn[i] == v && (m_attr[i].global_pg || m_asid[i] == a)) e_idx = i;
        checks++;
        if (e_idx < 0) begin
            ok = !lk_hit && lk_pfn == '0 && !lk_global && lk_rd_perm == '0 &&
                 lk_wr_perm == '0 && !lk_trap_rd && !lk_trap_wr;
            if (!ok) begin
                errors++;
                $display("FAIL %s: vpn %0h asid %0d got hit %0b pfn %0h exp miss with zero fields",
                         tag, v, a, lk_hit, lk_pfn);
            end
        end else begin
            ok = lk_hit && int'(lk_idx) == e_idx && lk_pfn == m_pfn[e_idx] &&
                 lk_global == m_attr[e_idx].global_pg && lk_rd_perm == m_attr[e_idx].rd_perm &&
                 lk_wr_perm == m_attr[e_idx].wr_perm && lk_trap_rd == m_attr[e_idx].trap_rd &&
                 lk_trap_wr == m_attr[e_idx].trap_wr;
            if (!ok) begin
                errors++;
                $display("FAIL %s: vpn %0h asid %0d got hit %0b idx %0d pfn %0h exp hit idx %0d pfn %0h",
                         tag, v, a, lk_hit, lk_idx, lk_pfn, e_idx, m_pfn[e_idx]);
            end
        end
    endtask

    task automatic sweep(input string tag);
        bit [VW-1:0] pages [5] = '{8'h10, 8'h20, 8'h30, 8'h40, 8'h55};
        for (int p = 0; p < 5; p++)
            for (int a = 0; a < 8; a++) probe(pages[p], 3'(a), tag);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5 * 150000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_vpn[i] = 0; m_asid[i] = 0; m_pfn[i] = 0; m_attr[i] = '0;
        end
        m_ptr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R9: empty after reset
        check_ptr("R9");
        sweep("R9");

        // R3 R4: fill all slots, same page under two identifiers, shared duplicate below a private one
        fill(0, 8'h10, 3'd1, 1'b0); check_ptr("R4");
        fill(1, 8'h10, 3'd2, 1'b0); check_ptr("R4");
        fill(2, 8'h20, 3'd3, 1'b1); check_ptr("R4");
        fill(3, 8'h20, 3'd3, 1'b0); check_ptr("R4");
        fill(4, 8'h30, 3'd0, 1'b0); check_ptr("R4");
        fill(5, 8'h40, 3'd6, 1'b1); check_ptr("R4 wrap");
        sweep("R1 R2 R3");

        // R3: eviction of slot 0 by a new page, then of slot 1 by a shared copy of 0x10
        fill(6, 8'h55, 3'd4, 1'b0); check_ptr("R4");
        sweep("R3 evict");
        fill(7, 8'h10, 3'd5, 1'b1); check_ptr("R4");
        sweep("R3 R2");

        // R5: skip twice, nothing written
        issue(5, 8'h30, 3'd0, 8'hFF, attr_for(9, 1'b1)); check_ptr("R5");
        issue(5, 8'h30, 3'd0, 8'hFF, attr_for(9, 1'b1)); check_ptr("R5");
        sweep("R5");
        fill(8, 8'h30, 3'd7, 1'b0); check_ptr("R5 R4");
        sweep("R3");

        // R10: idle and unused codes
        issue(6, 8'h10, 3'd5, 8'h11, attr_for(1, 1'b0)); check_ptr("R10");
        issue(7, 8'h20, 3'd3, 8'h22, attr_for(2, 1'b0)); check_ptr("R10");
        issue(0, 8'h30, 3'd7, 8'h33, attr_for(3, 1'b0)); check_ptr("R10");
        sweep("R10");

        // R8: flush-one, by shared slot and by identifier
        issue(4, 8'h20, 3'd5, 8'h00, '0); check_ptr("R8");
        sweep("R8 shared");
        issue(4, 8'h30, 3'd0, 8'h00, '0); check_ptr("R8");
        sweep("R8 asid");

        // R7: flush-private
        fill(9, 8'h20, 3'd2, 1'b0);
        issue(3, 8'h00, 3'd0, 8'h00, '0); check_ptr("R7");
        sweep("R7");

        // R6: flush-all, then refill starts at slot 0
        issue(2, 8'h00, 3'd0, 8'h00, '0); check_ptr("R6");
        sweep("R6");
        fill(10, 8'h40, 3'd1, 1'b0); check_ptr("R6 R4");
        sweep("R6 R3");

        summary();
    end
endmodule